// File: doc/BRIEF.md
# Handset Power-Up Sequencing Controller

This controller brings two supply rails of a handset processor up and down in a fixed order. A power-up can be started by either an on/off key or an active-low charger-detect line, each filtered by its own debouncer. The first rail is enabled right away. The second rail follows a selectable delay once the first rail reports power-good. The processor reset is released a further delay after the second rail reports power-good.

After reset release, the processor must raise its hold line before a timeout expires, or the controller shuts the rails down again. A key-started power-up drives the interrupt line low until the processor answers or the timeout expires. A charger-started power-up leaves the interrupt line high.

Shutdown reverses the power-up order. First the reset is pulled low. After the reset delay the second rail is disabled. Once its power-good has fallen and the inter-rail delay has passed, the first rail is disabled. While the charger is present, the hold line alone cannot switch the system off. A drop of either power-good flag while the reset is released forces an immediate reset and a shutdown. All delays are parameters counted in clock ticks.

Top module: `handset_pwr_seq`

## Requirements
- R1: A key-started power-up needs the key input high for DEBOUNCE_TICKS consecutive cycles. The key input is sampled at each clock edge. When the input has been high for that long, rail 1 enable rises and the interrupt output (active low) falls together, DEBOUNCE_TICKS+1 cycles after the key input rises.
- R2: Rail 2 enable rises 1+D cycles after rail 1 power-good rises. D is RAIL_DLY_STD when the delay select input is 0 and RAIL_DLY_SLOW when it is 1. Rail 2 is never enabled unless rail 1 is enabled.
- R3: The reset output (active low) goes high 1+RESET_DLY cycles after rail 2 power-good rises.
- R4: If the hold input goes high while the reset is released and the hold timer is running, the interrupt output goes high 1 cycle later. Both rails and the reset stay on.
- R5: If the hold input stays low for HOLD_TICKS cycles after reset release, with no charger present, the reset goes low and the interrupt goes high in that same cycle. The shutdown sequence then follows.
- R6: Shutdown runs in reverse order. When the hold input falls while running, the reset goes low 1 cycle later. Rail 2 is disabled RESET_DLY cycles after that. Rail 1 is disabled 1+D cycles after rail 2 power-good falls.
- R7: If either power-good flag is low while the reset is released, the reset goes low on the next cycle, and shutdown follows as in R6.
- R8: A debounced charger assertion (charger input low) while the system is off starts the same power-up, DEBOUNCE_TICKS+1 cycles after the charger input falls. The interrupt stays high throughout. A key press arriving at the same time does not pull the interrupt low.
- R9: While the charger is asserted, no output changes in response to the charger arriving while the system is on, to the hold input being low, or to the hold timer expiring. Shutdown begins with the reset going low DEBOUNCE_TICKS+1 cycles after the charger input returns high, provided the hold input is low.
- R10: A further debounced key press while the system is running changes no output.
- R11: A key input that drops low before the debounce period ends restarts the count. Power-up then follows DEBOUNCE_TICKS+1 cycles after the final rise.
- R12: While the synchronous reset is high, and right after it is released, both rail enables are low, the reset output is low and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | 1 | On/off key, active high |
| chg_n_i | input | 1 | Charger detect, active low |
| hold_i | input | 1 | Processor hold line, high keeps power on |
| pg1_i | input | 1 | Rail 1 power-good flag |
| pg2_i | input | 1 | Rail 2 power-good flag |
| slow_dly_i | input | 1 | 1 selects the long inter-rail delay |
| rail1_en_o | output | 1 | Rail 1 enable |
| rail2_en_o | output | 1 | Rail 2 enable |
| sys_rst_n_o | output | 1 | Processor reset, active low |
| key_irq_n_o | output | 1 | Key interrupt, active low |

## Verification
Every output is a decode of the registered sequencer state, so a result is due a whole number of clock edges after the input that causes it. A debounced key or charger edge adds DEBOUNCE_TICKS+1 edges. A power-good edge adds one edge plus the delay in force. A hold or fault edge adds exactly one edge. The bench applies each stimulus between edges and then counts edges until the output moves, comparing that count with the figure in the requirement. Where a requirement says nothing should happen, the bench watches all four outputs on every cycle of a window longer than any delay that could be involved.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_R1_UP,
        S_R1_WAIT,
        S_R2_UP,
        S_RST_WAIT,
        S_HOLD_WAIT,
        S_RUN,
        S_DN_RST,
        S_DN_R2,
        S_DN_WAIT
    } seq_state_e;

    typedef struct packed {
        logic en1;
        logic en2;
        logic rst_n;
    } rail_ctl_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic rail_ctl_t decode_state(input seq_state_e s);
        rail_ctl_t c;
        c.en1   = (s != S_OFF);
        c.en2   = (s == S_R2_UP) || (s == S_RST_WAIT) || (s == S_HOLD_WAIT) ||
                  (s == S_RUN)   || (s == S_DN_RST);
        c.rst_n = (s == S_HOLD_WAIT) || (s == S_RUN);
        return c;
    endfunction

endpackage

// File: rtl/pwr_seq_debounce.sv
module pwr_seq_debounce #(
    parameter int TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            level_o <= 1'b0;
            rise_o  <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            if (raw_i == level_o) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                cnt     <= '0;
                level_o <= raw_i;
                rise_o  <= raw_i;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_LEVEL_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_o) |-> ($past(raw_i) == level_o)); // R11

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int RAIL_DLY_STD  = 4,
    parameter int RAIL_DLY_SLOW = 12,
    parameter int RESET_DLY     = 20,
    parameter int HOLD_TICKS    = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic key_rise_i,
    input  logic chg_act_i,
    input  logic hold_i,
    input  logic pg1_i,
    input  logic pg2_i,
    input  logic slow_dly_i,
    output logic rail1_en_o,
    output logic rail2_en_o,
    output logic sys_rst_n_o,
    output logic key_irq_n_o
);
    localparam int MAXD = max_of(max_of(RAIL_DLY_STD, RAIL_DLY_SLOW),
                                 max_of(RESET_DLY, HOLD_TICKS));
    localparam int CW = $clog2(MAXD + 1);
    localparam logic [CW-1:0] LIM_STD  = CW'(RAIL_DLY_STD - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(RAIL_DLY_SLOW - 1);
    localparam logic [CW-1:0] LIM_RST  = CW'(RESET_DLY - 1);
    localparam logic [CW-1:0] LIM_HOLD = CW'(HOLD_TICKS - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rail_lim;
    logic          irq_q, irq_d;
    logic          fault;
    rail_ctl_t     ctl;

    assign rail_lim = slow_dly_i ? LIM_SLOW : LIM_STD;
    assign fault    = !pg1_i || !pg2_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:       if (chg_act_i || key_rise_i) state_d = S_R1_UP;
            S_R1_UP:     if (pg1_i) state_d = S_R1_WAIT;
            S_R1_WAIT:   if (cnt_q == rail_lim) state_d = S_R2_UP;
            S_R2_UP:     if (pg2_i) state_d = S_RST_WAIT;
            S_RST_WAIT:  if (cnt_q == LIM_RST) state_d = S_HOLD_WAIT;
            S_HOLD_WAIT: begin
                if (fault)                  state_d = S_DN_RST;
                else if (hold_i)            state_d = S_RUN;
                else if (cnt_q == LIM_HOLD) state_d = chg_act_i ? S_RUN : S_DN_RST;
            end
            S_RUN: begin
                if (fault || (!hold_i && !chg_act_i)) state_d = S_DN_RST;
            end
            S_DN_RST:    if (cnt_q == LIM_RST) state_d = S_DN_R2;
            S_DN_R2:     if (!pg2_i) state_d = S_DN_WAIT;
            S_DN_WAIT:   if (cnt_q == rail_lim) state_d = S_OFF;
            default:     state_d = S_OFF;
        endcase
    end

    always_comb begin
        irq_d = irq_q;
        if (state_q == S_OFF && !chg_act_i && key_rise_i)
            irq_d = 1'b1;
        else if ((state_q == S_HOLD_WAIT && state_d != S_HOLD_WAIT) || state_d == S_OFF)
            irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ctl         = decode_state(state_q);
    assign rail1_en_o  = ctl.en1;
    assign rail2_en_o  = ctl.en2;
    assign sys_rst_n_o = ctl.rst_n;
    assign key_irq_n_o = !irq_q;

    AST_RAIL2_AFTER_RAIL1: assert property (@(posedge clk) disable iff (rst)
        $rose(rail2_en_o) |-> (rail1_en_o && $past(rail1_en_o))); // R2

    AST_RESET_AFTER_RAILS: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n_o) |-> (rail2_en_o && $past(rail2_en_o))); // R3

    AST_RAIL2_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rail2_en_o) |-> $past(!sys_rst_n_o)); // R6

    AST_RAIL1_OFF_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(rail1_en_o) |-> (!rail2_en_o && $past(!rail2_en_o))); // R6

    AST_FAULT_RESET: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_n_o && fault) |=> !sys_rst_n_o); // R7

    AST_IRQ_ONLY_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(key_irq_n_o) |-> ($past(state_q) == S_OFF && $past(key_rise_i))); // R1

endmodule

// File: rtl/handset_pwr_seq.sv
module handset_pwr_seq #(
    parameter int DEBOUNCE_TICKS = 32,
    parameter int RAIL_DLY_STD   = 4,
    parameter int RAIL_DLY_SLOW  = 12,
    parameter int RESET_DLY      = 20,
    parameter int HOLD_TICKS     = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic key_i,
    input  logic chg_n_i,
    input  logic hold_i,
    input  logic pg1_i,
    input  logic pg2_i,
    input  logic slow_dly_i,
    output logic rail1_en_o,
    output logic rail2_en_o,
    output logic sys_rst_n_o,
    output logic key_irq_n_o
);
    localparam int NSRC    = 2;
    localparam int SRC_KEY = 0;
    localparam int SRC_CHG = 1;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] level;
    logic [NSRC-1:0] rise;

    assign raw[SRC_KEY] = key_i;
    assign raw[SRC_CHG] = !chg_n_i;

    for (genvar g = 0; g < NSRC; g++) begin : g_db
        pwr_seq_debounce #(.TICKS(DEBOUNCE_TICKS)) u_db (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[g]),
            .level_o(level[g]),
            .rise_o (rise[g])
        );
    end

    pwr_seq_fsm #(
        .RAIL_DLY_STD (RAIL_DLY_STD),
        .RAIL_DLY_SLOW(RAIL_DLY_SLOW),
        .RESET_DLY    (RESET_DLY),
        .HOLD_TICKS   (HOLD_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .key_rise_i (rise[SRC_KEY]),
        .chg_act_i  (level[SRC_CHG]),
        .hold_i     (hold_i),
        .pg1_i      (pg1_i),
        .pg2_i      (pg2_i),
        .slow_dly_i (slow_dly_i),
        .rail1_en_o (rail1_en_o),
        .rail2_en_o (rail2_en_o),
        .sys_rst_n_o(sys_rst_n_o),
        .key_irq_n_o(key_irq_n_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!rail1_en_o && !rail2_en_o && !sys_rst_n_o && key_irq_n_o)); // R12

endmodule

// File: tb/handset_pwr_seq_test.sv
module handset_pwr_seq_test;
    localparam int DB   = 8;
    localparam int DSTD = 3;
    localparam int DSLW = 7;
    localparam int RD   = 5;
    localparam int HT   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key = 1'b0, chg_n = 1'b1, hold = 1'b0, pg1 = 1'b0, pg2 = 1'b0, slow = 1'b0;
    logic en1, en2, rstn, irqn;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    handset_pwr_seq #(
        .DEBOUNCE_TICKS(DB), .RAIL_DLY_STD(DSTD), .RAIL_DLY_SLOW(DSLW),
        .RESET_DLY(RD), .HOLD_TICKS(HT)
    ) uut (
        .clk(clk), .rst(rst), .key_i(key), .chg_n_i(chg_n), .hold_i(hold),
        .pg1_i(pg1), .pg2_i(pg2), .slow_dly_i(slow),
        .rail1_en_o(en1), .rail2_en_o(en2), .sys_rst_n_o(rstn), .key_irq_n_o(irqn)
    );

    function automatic logic out_sig(input int sel);
        case (sel)
            0: return en1;
            1: return en2;
            2: return rstn;
            default: return irqn;
        endcase
    endfunction

    task automatic check_int(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // counts edges until output sel equals val; returns -1 if not within lim
    task automatic edges_until(input int sel, input logic val, input int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_sig(sel) == val) begin
                n = i;
                break;
            end
        end
    endtask

    // all four outputs must keep {en1,en2,rstn,irqn} == exp for n cycles
    task automatic hold_steady(input string tag, input logic [3:0] exp, input int n);
        bit bad = 1'b0;
        logic [3:0] act = exp;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if ({en1, en2, rstn, irqn} != exp && !bad) begin
                bad = 1'b1;
                act = {en1, en2, rstn, irqn};
            end
        end
        check_int(tag, int'(act), int'(exp));
    endtask

    task automatic do_reset();
        key = 0; chg_n = 1; hold = 0; pg1 = 0; pg2 = 0; slow = 0;
        rst = 1;
        tick(3);
        check_int("R12 reset outputs during rst", int'({en1, en2, rstn, irqn}), 4'b0001);
        rst = 0;
        tick(1);
        check_int("R12 reset outputs after rst", int'({en1, en2, rstn, irqn}), 4'b0001);
    endtask

    // rails up after rail1 is enabled; returns with reset released
    task automatic rails_up(input int dly, input string tag);
        int n;
        tick(2);
        pg1 = 1;
        edges_until(1, 1'b1, 200, n);
        check_int({tag, " R2 rail2 enable latency"}, n, 1 + dly);
        tick(1);
        pg2 = 1;
        edges_until(2, 1'b1, 200, n);
        check_int({tag, " R3 reset release latency"}, n, 1 + RD);
    endtask

    // from reset just pulled low: rail2 off then rail1 off
    task automatic rails_down(input int dly, input string tag);
        int n;
        edges_until(1, 1'b0, 200, n);
        check_int({tag, " R6 rail2 off after reset low"}, n, RD);
        check_int({tag, " R6 rail1 still on"}, int'(en1), 1);
        tick(1);
        pg2 = 0;
        edges_until(0, 1'b0, 200, n);
        check_int({tag, " R6 rail1 off after pg2 fall"}, n, 1 + dly);
        pg1 = 0;
        tick(2);
    endtask

    task automatic t_key_hold_shutdown();
        int n;
        do_reset();
        key = 1;
        edges_until(0, 1'b1, 200, n);
        check_int("R1 rail1 enable latency", n, DB + 1);
        check_int("R1 irq low with rail1", int'(irqn), 0);
        key = 0;
        rails_up(DSTD, "std");
        tick(3);
        hold = 1;
        edges_until(3, 1'b1, 200, n);
        check_int("R4 irq release latency", n, 1);
        hold_steady("R4 system stays on", 4'b1111, HT + 5);
        key = 1;
        tick(DB + 3);
        key = 0;
        hold_steady("R10 second key press no effect", 4'b1111, 10);
        hold = 0;
        edges_until(2, 1'b0, 200, n);
        check_int("R6 reset low after hold fall", n, 1);
        rails_down(DSTD, "std");
    endtask

    task automatic t_hold_timeout_slow();
        int n;
        do_reset();
        slow = 1;
        key = 1;
        edges_until(0, 1'b1, 200, n);
        check_int("R1 rail1 enable latency (slow)", n, DB + 1);
        key = 0;
        rails_up(DSLW, "slow");
        edges_until(2, 1'b0, 200, n);
        check_int("R5 hold timeout reset low", n, HT);
        check_int("R5 irq high at timeout", int'(irqn), 1);
        rails_down(DSLW, "slow");
    endtask

    task automatic t_glitch_fault();
        int n;
        do_reset();
        key = 1;
        tick(DB - 1);
        key = 0;
        tick(1);
        check_int("R11 no power-up after glitch", int'(en1), 0);
        key = 1;
        edges_until(0, 1'b1, 200, n);
        check_int("R11 debounce restarts after glitch", n, DB + 1);
        key = 0;
        rails_up(DSTD, "glitch");
        hold = 1;
        tick(3);
        pg1 = 0;
        edges_until(2, 1'b0, 200, n);
        check_int("R7 fault reset latency", n, 1);
        hold = 0;
        rails_down(DSTD, "fault");
    endtask

    task automatic t_charger_start();
        int n;
        do_reset();
        chg_n = 0;
        key = 1;
        edges_until(0, 1'b1, 200, n);
        check_int("R8 charger rail1 enable latency", n, DB + 1);
        check_int("R8 irq stays high", int'(irqn), 1);
        rails_up(DSTD, "chg");
        check_int("R8 irq high after reset release", int'(irqn), 1);
        key = 0;
        hold_steady("R9 hold timeout masked by charger", 4'b1111, HT + 5);
        chg_n = 1;
        edges_until(2, 1'b0, 200, n);
        check_int("R9 shutdown after charger release", n, DB + 1);
        rails_down(DSTD, "chg");
    endtask

    task automatic t_charger_while_on();
        int n;
        do_reset();
        key = 1;
        edges_until(0, 1'b1, 200, n);
        key = 0;
        rails_up(DSTD, "on");
        hold = 1;
        tick(2);
        chg_n = 0;
        hold_steady("R9 charger arrival no change", 4'b1111, DB + 5);
        hold = 0;
        hold_steady("R9 hold low ignored with charger", 4'b1111, 15);
        chg_n = 1;
        edges_until(2, 1'b0, 200, n);
        check_int("R9 charger release shutdown latency", n, DB + 1);
        rails_down(DSTD, "on");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        tick(1);
        t_key_hold_shutdown();
        t_hold_timeout_slow();
        t_glitch_fault();
        t_charger_start();
        t_charger_while_on();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule